// File: doc/BRIEF.md
# Banked BCD Calendar Clock Registers

This block is the counting core of a calendar clock. Seconds, minutes, hours, day of week, day of month, month and a four-digit year are each kept as separate 4-bit BCD digits. Software reaches them over a nibble-wide register port with a 4-bit address and separate read and write strobes. A once-per-second tick pulse from an external prescaler advances the time, and the carries ripple through the calendar. Hours use 24-hour form, the day of week runs 0 to 6, month lengths are honoured, and the Gregorian leap rule is applied.

One control register sits at the top address in every bank. It holds a 2-bit bank select, a stop bit and a read-only busy flag. The digits live only in bank 0. Busy stays high for a short fixed window after each accepted tick, and the new time is committed when that window closes, so software polls busy before it reads. To load a new time, software sets stop, writes the digits and then clears stop.

Top module: `calendar_regs`

## Requirements
- R1: After reset every time digit reads 0, and the control register reads 0 (bank 0, stop 0, busy 0).
- R2: A read strobe in one cycle returns the addressed nibble on rdata_o in the next cycle. The control register at address 0xF is laid out as bit 0 busy, bit 1 stop, bits 3:2 bank select.
- R3: A tick accepted while stop is 0 and busy is 0 raises busy for BUSY_CYCLES cycles. The time advances by exactly one second on the edge where busy falls. A tick that arrives while busy is high is dropped.
- R4: While stop is 1, ticks are ignored and the digits hold. Bank 0 addresses 0x0 to 0xE are, in order: seconds ones, seconds tens, minutes ones, minutes tens, hours ones, hours tens, day of week, day ones, day tens, month ones, month tens, year ones, year tens, year hundreds, year thousands. They can be written only while stop is 1 and busy is 0. Digit writes made while stop is 0 are ignored.
- R5: The digits are visible and writable only in bank 0. In banks 1 to 3, addresses 0x0 to 0xE read 0 and writes to them are ignored. The control register is reachable in every bank.
- R6: Seconds and minutes count 00 to 59, and the step from 59 to 00 carries into the next field.
- R7: Hours wrap from 23 to 00 and carry into the day. The day of week wraps from 6 to 0. The day of month wraps to 01 after the month's last day: 30 for April, June, September and November, 31 for the other months, and 28 or 29 for February.
- R8: February has 29 days when the year is divisible by 4, except for century years that are not divisible by 400.
- R9: The month wraps from 12 to 01 and increments the year. The year digits carry through the tens, hundreds and thousands, and 9999 wraps to 0000.
- R10: If a tick and a control write that sets stop land in the same cycle, the tick is still accepted and its second is still committed. Writes to the busy bit have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| addr_i | input | 4 | Register address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 4 | Write data nibble |
| rdata_o | output | 4 | Read data nibble, valid the cycle after the strobe |

## Verification
Two functions can fall in the same cycle: the acceptance of a second tick, and a software write to the control register that sets stop. The bench drives the tick pulse and the stop-setting write on the same clock edge. It then reads the control register, which must show both stop and busy. After the window it reads the seconds digit, which must have advanced by one. The stop bit must stay set, and later ticks must then be ignored.

// File: rtl/cal_pkg.sv
package cal_pkg;
    localparam int DIGIT_W   = 4;
    localparam int NUM_DIGIT = 15;
    localparam int ADDR_W    = 4;

    // Digit positions in bank 0; software depends on this order.
    localparam int P_SEC1  = 0;
    localparam int P_SEC10 = 1;
    localparam int P_MIN1  = 2;
    localparam int P_MIN10 = 3;
    localparam int P_HR1   = 4;
    localparam int P_HR10  = 5;
    localparam int P_DOW   = 6;
    localparam int P_DAY1  = 7;
    localparam int P_DAY10 = 8;
    localparam int P_MON1  = 9;
    localparam int P_MON10 = 10;
    localparam int P_YR1   = 11;
    localparam int P_YR10  = 12;
    localparam int P_YR100 = 13;
    localparam int P_YR1K  = 14;

    localparam logic [ADDR_W-1:0] CTRL_ADDR = 4'hF;

    typedef logic [NUM_DIGIT-1:0][DIGIT_W-1:0] digits_t;
endpackage

// File: rtl/cal_month_days.sv
module cal_month_days
    import cal_pkg::*;
(
    input  logic [DIGIT_W-1:0] mon_ones,
    input  logic [DIGIT_W-1:0] mon_tens,
    input  logic [3:0][DIGIT_W-1:0] year_dig,
    output logic [DIGIT_W-1:0] last_ones,
    output logic [DIGIT_W-1:0] last_tens
);
    logic [7:0] month_bin;
    logic [7:0] yr_low;
    logic [7:0] yr_high;
    logic       leap;

    always_comb begin
        month_bin = {4'b0, mon_tens} * 8'd10 + {4'b0, mon_ones};
        yr_low    = {4'b0, year_dig[1]} * 8'd10 + {4'b0, year_dig[0]};
        yr_high   = {4'b0, year_dig[3]} * 8'd10 + {4'b0, year_dig[2]};
        // Century years follow the upper two digits (R8).
        leap = (yr_low != 8'd0) ? (yr_low[1:0] == 2'b00) : (yr_high[1:0] == 2'b00);
        last_tens = 4'd3;
        last_ones = 4'd1;
        case (month_bin)
            8'd2: begin
                last_tens = 4'd2;
                last_ones = leap ? 4'd9 : 4'd8;
            end
            8'd4, 8'd6, 8'd9, 8'd11: last_ones = 4'd0;
            default: ;
        endcase
    end
endmodule

// File: rtl/cal_advance.sv
module cal_advance
    import cal_pkg::*;
(
    input  digits_t cur,
    output digits_t nxt
);
    logic [DIGIT_W-1:0] last_ones;
    logic [DIGIT_W-1:0] last_tens;
    logic c_sec, c_min, c_hr, c_day, c_mon, c_yr;

    cal_month_days u_days (
        .mon_ones (cur[P_MON1]),
        .mon_tens (cur[P_MON10]),
        .year_dig (cur[P_YR1K:P_YR1]),
        .last_ones(last_ones),
        .last_tens(last_tens)
    );

    always_comb begin
        nxt   = cur;
        c_sec = 1'b0;
        c_min = 1'b0;
        c_hr  = 1'b0;
        c_day = 1'b0;
        c_mon = 1'b0;
        c_yr  = 1'b0;
        // seconds (R6)
        if (cur[P_SEC1] == 4'd9) begin
            nxt[P_SEC1] = 4'd0;
            if (cur[P_SEC10] == 4'd5) begin
                nxt[P_SEC10] = 4'd0;
                c_sec = 1'b1;
            end else begin
                nxt[P_SEC10] = cur[P_SEC10] + 4'd1;
            end
        end else begin
            nxt[P_SEC1] = cur[P_SEC1] + 4'd1;
        end
        // minutes (R6)
        if (c_sec) begin
            if (cur[P_MIN1] == 4'd9) begin
                nxt[P_MIN1] = 4'd0;
                if (cur[P_MIN10] == 4'd5) begin
                    nxt[P_MIN10] = 4'd0;
                    c_min = 1'b1;
                end else begin
                    nxt[P_MIN10] = cur[P_MIN10] + 4'd1;
                end
            end else begin
                nxt[P_MIN1] = cur[P_MIN1] + 4'd1;
            end
        end
        // hours, 24-hour form (R7)
        if (c_min) begin
            if (cur[P_HR10] == 4'd2 && cur[P_HR1] == 4'd3) begin
                nxt[P_HR1]  = 4'd0;
                nxt[P_HR10] = 4'd0;
                c_hr = 1'b1;
            end else if (cur[P_HR1] == 4'd9) begin
                nxt[P_HR1]  = 4'd0;
                nxt[P_HR10] = cur[P_HR10] + 4'd1;
            end else begin
                nxt[P_HR1] = cur[P_HR1] + 4'd1;
            end
        end
        // weekday and day of month (R7, R8)
        if (c_hr) begin
            nxt[P_DOW] = (cur[P_DOW] == 4'd6) ? 4'd0 : cur[P_DOW] + 4'd1;
            if (cur[P_DAY10] == last_tens && cur[P_DAY1] == last_ones) begin
                nxt[P_DAY1]  = 4'd1;
                nxt[P_DAY10] = 4'd0;
                c_day = 1'b1;
            end else if (cur[P_DAY1] == 4'd9) begin
                nxt[P_DAY1]  = 4'd0;
                nxt[P_DAY10] = cur[P_DAY10] + 4'd1;
            end else begin
                nxt[P_DAY1] = cur[P_DAY1] + 4'd1;
            end
        end
        // month (R9)
        if (c_day) begin
            if (cur[P_MON10] == 4'd1 && cur[P_MON1] == 4'd2) begin
                nxt[P_MON1]  = 4'd1;
                nxt[P_MON10] = 4'd0;
                c_mon = 1'b1;
            end else if (cur[P_MON1] == 4'd9) begin
                nxt[P_MON1]  = 4'd0;
                nxt[P_MON10] = 4'd1;
            end else begin
                nxt[P_MON1] = cur[P_MON1] + 4'd1;
            end
        end
        // year digit cascade (R9)
        c_yr = c_mon;
        for (int i = P_YR1; i <= P_YR1K; i++) begin
            if (c_yr) begin
                if (cur[i] == 4'd9) begin
                    nxt[i] = 4'd0;
                end else begin
                    nxt[i] = cur[i] + 4'd1;
                    c_yr   = 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/calendar_regs.sv
module calendar_regs
    import cal_pkg::*;
#(
    parameter int BUSY_CYCLES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    input  logic [DIGIT_W-1:0] wdata_i,
    output logic [DIGIT_W-1:0] rdata_o
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES);

    typedef struct packed {
        digits_t            dig;
        logic [1:0]         bank;
        logic               stop;
        logic [CNT_W-1:0]   busy_cnt;
        logic [DIGIT_W-1:0] rdata;
    } state_t;

    state_t  st_d, st_q;
    digits_t dig_next;
    logic    busy;
    logic    accept_tick;
    logic [DIGIT_W-1:0] rd_mux;

    cal_advance u_adv (
        .cur(st_q.dig),
        .nxt(dig_next)
    );

    always_comb begin
        busy        = (st_q.busy_cnt != '0);
        accept_tick = tick_i && !st_q.stop && !busy;

        if (addr_i == CTRL_ADDR)
            rd_mux = {st_q.bank, st_q.stop, busy};
        else if (st_q.bank == 2'd0)
            rd_mux = st_q.dig[addr_i];
        else
            rd_mux = '0;

        st_d = st_q;
        if (busy) begin
            st_d.busy_cnt = st_q.busy_cnt - 1'b1;
            if (st_q.busy_cnt == CNT_W'(1))
                st_d.dig = dig_next;
        end
        if (accept_tick)
            st_d.busy_cnt = CNT_LOAD;

        if (wr_en_i) begin
            if (addr_i == CTRL_ADDR) begin
                st_d.bank = wdata_i[3:2];
                st_d.stop = wdata_i[1];
            end else if (st_q.bank == 2'd0 && st_q.stop && !busy) begin
                st_d.dig[addr_i] = wdata_i;
            end
        end

        if (rd_en_i)
            st_d.rdata = rd_mux;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign rdata_o = st_q.rdata;

    a_r3_tick_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !st_q.stop && st_q.busy_cnt == '0) |=> (st_q.busy_cnt != '0));

    a_r3_commit_on_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy_cnt != '0) |-> !$stable(st_q.dig));

    a_r4_stopped_digits_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stop && st_q.busy_cnt == '0 && !wr_en_i) |=> $stable(st_q.dig));

    a_r5_other_bank_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && st_q.bank != 2'd0 && addr_i != CTRL_ADDR && st_q.busy_cnt == '0)
        |=> $stable(st_q.dig));

    a_r10_busy_bit_not_writable: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == CTRL_ADDR && !tick_i && st_q.busy_cnt == '0)
        |=> (st_q.busy_cnt == '0));
endmodule

// File: tb/tb_calendar_regs.sv
module tb_calendar_regs;
    import cal_pkg::*;

    typedef struct {
        logic [3:0] val;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic [3:0] addr_i = '0;
    logic       wr_en_i = 1'b0;
    logic       rd_en_i = 1'b0;
    logic [3:0] wdata_i = '0;
    logic [3:0] rdata_o;

    int   checks = 0;
    int   fails = 0;
    logic pend = 1'b0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #10 clk = ~clk;

    calendar_regs #(.BUSY_CYCLES(4)) dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .addr_i(addr_i),
        .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
    );

    always @(posedge clk) pend <= rd_en_i;

    // monitor: compare each returned nibble with the scoreboard head
    always @(negedge clk) begin
        if (pend) begin
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL scoreboard empty: actual %h expected none", rdata_o);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (rdata_o !== e.val) begin
                    fails++;
                    $display("FAIL %s: actual %h expected %h", e.tag, rdata_o, e.val);
                end
            end
        end
    end

    function automatic digits_t mk(int s, int m, int h, int w, int d, int mo, int y);
        digits_t v;
        v[P_SEC1]  = 4'(s % 10);  v[P_SEC10] = 4'(s / 10);
        v[P_MIN1]  = 4'(m % 10);  v[P_MIN10] = 4'(m / 10);
        v[P_HR1]   = 4'(h % 10);  v[P_HR10]  = 4'(h / 10);
        v[P_DOW]   = 4'(w);
        v[P_DAY1]  = 4'(d % 10);  v[P_DAY10] = 4'(d / 10);
        v[P_MON1]  = 4'(mo % 10); v[P_MON10] = 4'(mo / 10);
        v[P_YR1]   = 4'(y % 10);  v[P_YR10]  = 4'((y / 10) % 10);
        v[P_YR100] = 4'((y / 100) % 10); v[P_YR1K] = 4'(y / 1000);
        return v;
    endfunction

    task automatic wr(input logic [3:0] a, input logic [3:0] d, input bit t = 1'b0);
        @(negedge clk);
        addr_i = a; wdata_i = d; wr_en_i = 1'b1; tick_i = t;
        @(negedge clk);
        wr_en_i = 1'b0; tick_i = 1'b0;
    endtask

    // driver: issue a read and push the expected nibble
    task automatic rd(input logic [3:0] a, input logic [3:0] e, input string tag);
        exp_t x;
        @(negedge clk);
        addr_i = a; rd_en_i = 1'b1;
        x.val = e; x.tag = tag;
        sb.push_back(x);
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    task automatic tick_pulse();
        @(negedge clk);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    task automatic set_time(input digits_t v);
        wr(CTRL_ADDR, 4'b0010);
        for (int i = 0; i < NUM_DIGIT; i++) wr(4'(i), v[i]);
        wr(CTRL_ADDR, 4'b0000);
    endtask

    task automatic expect_all(input digits_t v, input string tag);
        for (int i = 0; i < NUM_DIGIT; i++)
            rd(4'(i), v[i], $sformatf("%s digit %0d", tag, i));
    endtask

    task automatic step_case(input digits_t from, input digits_t to, input string tag);
        set_time(from);
        tick_pulse();
        settle();
        expect_all(to, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        rd(CTRL_ADDR, 4'h0, "R1 control after reset");
        rd(4'h0, 4'h0, "R1 seconds ones after reset");
        rd(4'hE, 4'h0, "R1 year thousands after reset");

        step_case(mk(59,59,23,6,31,12,2023), mk(0,0,0,0,1,1,2024), "R9 new year");
        step_case(mk(59,59,23,2,28,2,2024),  mk(0,0,0,3,29,2,2024), "R8 leap 2024");
        step_case(mk(59,59,23,2,28,2,2023),  mk(0,0,0,3,1,3,2023),  "R8 non-leap 2023");
        step_case(mk(59,59,23,0,28,2,2100),  mk(0,0,0,1,1,3,2100),  "R8 century 2100");
        step_case(mk(59,59,23,1,28,2,2000),  mk(0,0,0,2,29,2,2000), "R8 century 2000");
        step_case(mk(59,59,23,4,29,2,2024),  mk(0,0,0,5,1,3,2024),  "R7 leap day end");
        step_case(mk(59,59,23,5,30,4,2024),  mk(0,0,0,6,1,5,2024),  "R7 thirty-day month");
        step_case(mk(59,59,19,3,9,7,2024),   mk(0,0,20,3,9,7,2024), "R7 hour tens");
        step_case(mk(59,59,23,6,31,12,9999), mk(0,0,0,0,1,1,0),     "R9 year wrap");
        step_case(mk(59,59,23,6,31,12,1999), mk(0,0,0,0,1,1,2000),  "R9 millennium");
        step_case(mk(59,9,12,1,5,3,2024),    mk(0,10,12,1,5,3,2024), "R6 minute ones carry");
        step_case(mk(59,59,10,1,5,3,2024),   mk(0,0,11,1,5,3,2024), "R6 hour carry");

        // R3 busy window and commit
        set_time(mk(0,0,0,0,1,1,2024));
        tick_pulse();
        rd(CTRL_ADDR, 4'b0001, "R2 R3 busy during window");
        rd(4'h0, 4'h0, "R3 digit not yet committed");
        settle();
        rd(CTRL_ADDR, 4'b0000, "R3 busy cleared");
        rd(4'h0, 4'h1, "R3 second committed");

        // R4 stop freezes, writes ignored while running
        wr(CTRL_ADDR, 4'b0010);
        tick_pulse();
        settle();
        rd(4'h0, 4'h1, "R4 stopped ignores tick");
        rd(CTRL_ADDR, 4'b0010, "R4 stop visible");
        wr(CTRL_ADDR, 4'b0000);
        wr(4'h0, 4'h7);
        rd(4'h0, 4'h1, "R4 write ignored while running");

        // R5 bank decoding
        wr(CTRL_ADDR, 4'b0100);
        rd(CTRL_ADDR, 4'b0100, "R5 control in bank 1");
        rd(4'h0, 4'h0, "R5 bank 1 digit reads zero");
        wr(CTRL_ADDR, 4'b0110);
        wr(4'h0, 4'h5);
        wr(CTRL_ADDR, 4'b1110);
        rd(CTRL_ADDR, 4'b1110, "R5 control in bank 3");
        wr(CTRL_ADDR, 4'b0010);
        rd(4'h0, 4'h1, "R5 bank 0 digit untouched");
        wr(CTRL_ADDR, 4'b0000);

        // R10 tick together with a stop-setting write
        wr(CTRL_ADDR, 4'b0010, 1'b1);
        rd(CTRL_ADDR, 4'b0011, "R10 stop and busy together");
        settle();
        rd(4'h0, 4'h2, "R10 tick still committed");
        rd(CTRL_ADDR, 4'b0010, "R10 stop held after window");
        tick_pulse();
        settle();
        rd(4'h0, 4'h2, "R10 later tick ignored");
        wr(CTRL_ADDR, 4'b0001);
        rd(CTRL_ADDR, 4'b0000, "R10 busy bit not writable");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements): actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule